// File: doc/BRIEF.md
# Dual-Processor Doorbell Flag Controller

This block lets two processors signal each other over a small set of doorbell channels. Each channel carries one flag per direction. The sending processor owns its flag. The receiving processor sees a set flag as an occupied channel that holds a message. The sender sees a clear flag as a free channel that it may reuse. A processor raises its own flag with a write-one set command. The partner processor lowers that flag with a write-one clear command once it has consumed the message. No other path frees a channel.

Each processor has a private register port with four word registers:

| Offset | Register | Access | Contents |
|--------|----------|--------|----------|
| 0x0 | control | read/write | bit 0 receive-occupied interrupt enable, bit 1 transmit-free interrupt enable |
| 0x4 | mask | read/write | bits [5:0] receive-occupied masks, bits [21:16] transmit-free masks; a mask bit of 1 disables that channel |
| 0x8 | command | write-only | bits [5:0] clear the flag received on the channel, bits [21:16] set the processor's own flag |
| 0xC | status | read-only | bits [5:0] the flags this processor has raised |

Each processor gets one receive-occupied interrupt and one transmit-free interrupt. Both are level outputs built from the flags, the masks and the global enables.

Top module: `mbox_doorbell`

## Requirements
- R1: After reset both processors read status 0, mask 0x003F003F and control 0, and all four interrupts are low.
- R2: Writing the command register with bit 16+k set raises the writer's own flag for channel k, which shows as status bit k from the next cycle. Command bits written as 0 leave flags unchanged.
- R3: Writing the command register with bit k set (k in 0..5) clears the partner processor's flag for channel k. The writer's own flags are unchanged.
- R4: If a set and a clear reach the same flag in the same cycle, the flag ends up set.
- R5: A processor's receive-occupied interrupt is high exactly when control bit 0 is 1 and some channel k has the partner's flag set while receive mask bit k is 0.
- R6: A processor's transmit-free interrupt is high exactly when control bit 1 is 1 and some channel k has the processor's own flag clear while transmit mask bit k (mask bit 16+k) is 0.
- R7: Control and mask read back what was written, limited to their defined bits. The command register reads 0. A write to status has no effect.
- R8: The two processors' control, mask and flag state are independent. A write on one port changes the other port's view only through the flag it sets or clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_sel | input | 1 | Processor A access strobe |
| a_wr | input | 1 | Processor A write (1) or read (0) |
| a_addr | input | 4 | Processor A byte offset |
| a_wdata | input | 32 | Processor A write data |
| a_rdata | output | 32 | Processor A read data (combinational) |
| b_sel | input | 1 | Processor B access strobe |
| b_wr | input | 1 | Processor B write (1) or read (0) |
| b_addr | input | 4 | Processor B byte offset |
| b_wdata | input | 32 | Processor B write data |
| b_rdata | output | 32 | Processor B read data (combinational) |
| a_irq_rx | output | 1 | Processor A receive-occupied interrupt |
| a_irq_tx | output | 1 | Processor A transmit-free interrupt |
| b_irq_rx | output | 1 | Processor B receive-occupied interrupt |
| b_irq_tx | output | 1 | Processor B transmit-free interrupt |

## Verification
The flag assertions assume that each bus access lasts exactly one clock and that the offsets are word-aligned. The stimulus drives every access for a single cycle on the falling edge with aligned offsets. The assertions also assume that a flag moves only through command-register writes. The bench therefore touches flags only through command writes, and it drives a simultaneous set and clear on the same channel in one cycle to exercise the priority rule.

// File: rtl/mbox_doorbell.sv
module mbox_doorbell #(
  parameter int NCH = 6,
  parameter int DW  = 32,
  parameter int AW  = 4,
  parameter int HI  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_sel,
  input  logic          a_wr,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_sel,
  input  logic          b_wr,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          a_irq_rx,
  output logic          a_irq_tx,
  output logic          b_irq_rx,
  output logic          b_irq_tx
);
  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_MASK = 2'd1;
  localparam logic [1:0] OFS_CMD  = 2'd2;
  localparam logic [1:0] OFS_STAT = 2'd3;

  logic [1:0]     a_ctrl, b_ctrl;
  logic [NCH-1:0] a_rxm, a_txm, b_rxm, b_txm;
  logic [NCH-1:0] a_flag, b_flag;

  logic a_wcmd, b_wcmd, a_wctl, b_wctl, a_wmsk, b_wmsk;
  logic [NCH-1:0] a_set, a_clr, b_set, b_clr;

  assign a_wctl = a_sel & a_wr & (a_addr[3:2] == OFS_CTRL);
  assign a_wmsk = a_sel & a_wr & (a_addr[3:2] == OFS_MASK);
  assign a_wcmd = a_sel & a_wr & (a_addr[3:2] == OFS_CMD);
  assign b_wctl = b_sel & b_wr & (b_addr[3:2] == OFS_CTRL);
  assign b_wmsk = b_sel & b_wr & (b_addr[3:2] == OFS_MASK);
  assign b_wcmd = b_sel & b_wr & (b_addr[3:2] == OFS_CMD);

  assign a_set = a_wcmd ? a_wdata[HI+NCH-1:HI] : '0;
  assign a_clr = a_wcmd ? a_wdata[NCH-1:0]     : '0;
  assign b_set = b_wcmd ? b_wdata[HI+NCH-1:HI] : '0;
  assign b_clr = b_wcmd ? b_wdata[NCH-1:0]     : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_ctrl <= '0;
      b_ctrl <= '0;
      a_rxm  <= '1;
      a_txm  <= '1;
      b_rxm  <= '1;
      b_txm  <= '1;
      a_flag <= '0;
      b_flag <= '0;
    end else begin
      if (a_wctl) a_ctrl <= a_wdata[1:0];
      if (b_wctl) b_ctrl <= b_wdata[1:0];
      if (a_wmsk) begin
        a_rxm <= a_wdata[NCH-1:0];
        a_txm <= a_wdata[HI+NCH-1:HI];
      end
      if (b_wmsk) begin
        b_rxm <= b_wdata[NCH-1:0];
        b_txm <= b_wdata[HI+NCH-1:HI];
      end
      a_flag <= a_set | (a_flag & ~b_clr);
      b_flag <= b_set | (b_flag & ~a_clr);
    end
  end

  function automatic logic [DW-1:0] rd_mux(input logic [1:0] sel_ofs,
                                           input logic [1:0] ctl,
                                           input logic [NCH-1:0] rxm,
                                           input logic [NCH-1:0] txm,
                                           input logic [NCH-1:0] own);
    logic [DW-1:0] r;
    r = '0;
    case (sel_ofs)
      OFS_CTRL: r[1:0] = ctl;
      OFS_MASK: begin
        r[NCH-1:0]       = rxm;
        r[HI+NCH-1:HI]   = txm;
      end
      OFS_STAT: r[NCH-1:0] = own;
      default:  r = '0;
    endcase
    return r;
  endfunction

  assign a_rdata = (a_sel & ~a_wr) ? rd_mux(a_addr[3:2], a_ctrl, a_rxm, a_txm, a_flag) : '0;
  assign b_rdata = (b_sel & ~b_wr) ? rd_mux(b_addr[3:2], b_ctrl, b_rxm, b_txm, b_flag) : '0;

  assign a_irq_rx = a_ctrl[0] & |(b_flag & ~a_rxm);
  assign a_irq_tx = a_ctrl[1] & |(~a_flag & ~a_txm);
  assign b_irq_rx = b_ctrl[0] & |(a_flag & ~b_rxm);
  assign b_irq_tx = b_ctrl[1] & |(~b_flag & ~b_txm);
endmodule

// File: rtl/mbox_doorbell_chk.sv
module mbox_doorbell_chk #(
  parameter int NCH = 6,
  parameter int DW  = 32,
  parameter int AW  = 4,
  parameter int HI  = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_sel,
  input logic          a_wr,
  input logic [AW-1:0] a_addr,
  input logic [DW-1:0] a_wdata,
  input logic          b_sel,
  input logic          b_wr,
  input logic [AW-1:0] b_addr,
  input logic [DW-1:0] b_wdata,
  input logic [NCH-1:0] a_flag,
  input logic [NCH-1:0] b_flag,
  input logic [1:0]    a_ctrl,
  input logic [NCH-1:0] a_txm,
  input logic          a_irq_rx,
  input logic          a_irq_tx
);
  logic a_cmd, b_cmd;
  logic [NCH-1:0] a_s, b_c;
  assign a_cmd = a_sel && a_wr && a_addr == 4'h8;
  assign b_cmd = b_sel && b_wr && b_addr == 4'h8;
  assign a_s = a_cmd ? a_wdata[HI+NCH-1:HI] : '0;
  assign b_c = b_cmd ? b_wdata[NCH-1:0] : '0;

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    a_cmd |=> ((a_flag & $past(a_s)) == $past(a_s)));                       // R2
  AST_CLEAR_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    b_cmd |=> ((a_flag & $past(b_c & ~a_s)) == '0));                        // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (a_cmd && b_cmd && |(a_s & b_c)) |=> ((a_flag & $past(a_s & b_c)) != '0)); // R4
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_cmd && !b_cmd) |=> $stable(a_flag));                                // R8
  AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !a_ctrl[0] |-> !a_irq_rx);                                              // R5
  AST_TX_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (&a_txm) |-> !a_irq_tx);                                                // R6
endmodule

bind mbox_doorbell mbox_doorbell_chk #(.NCH(NCH), .DW(DW), .AW(AW), .HI(HI)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata),
  .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata),
  .a_flag(a_flag), .b_flag(b_flag), .a_ctrl(a_ctrl), .a_txm(a_txm),
  .a_irq_rx(a_irq_rx), .a_irq_tx(a_irq_tx)
);

// File: tb/mbox_doorbell_tb.sv
module mbox_doorbell_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_sel = 0, a_wr = 0, b_sel = 0, b_wr = 0;
  logic [3:0] a_addr = '0, b_addr = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic a_irq_rx, a_irq_tx, b_irq_rx, b_irq_tx;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  mbox_doorbell u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_a(input logic [3:0] ad, input logic [31:0] d);
    @(negedge clk); a_sel = 1; a_wr = 1; a_addr = ad; a_wdata = d;
    @(negedge clk); a_sel = 0; a_wr = 0; a_wdata = '0;
  endtask

  task automatic wr_b(input logic [3:0] ad, input logic [31:0] d);
    @(negedge clk); b_sel = 1; b_wr = 1; b_addr = ad; b_wdata = d;
    @(negedge clk); b_sel = 0; b_wr = 0; b_wdata = '0;
  endtask

  task automatic rd_a(input logic [3:0] ad, output logic [31:0] d);
    @(negedge clk); a_sel = 1; a_wr = 0; a_addr = ad;
    #1 d = a_rdata;
    a_sel = 0;
  endtask

  task automatic rd_b(input logic [3:0] ad, output logic [31:0] d);
    @(negedge clk); b_sel = 1; b_wr = 0; b_addr = ad;
    #1 d = b_rdata;
    b_sel = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd_a(4'hC, d); check("R1 status A", d, 32'h0);
    rd_b(4'hC, d); check("R1 status B", d, 32'h0);
    rd_a(4'h4, d); check("R1 mask A", d, 32'h003F003F);
    rd_b(4'h0, d); check("R1 ctrl B", d, 32'h0);
    check("R1 irqs", {28'h0, a_irq_rx, a_irq_tx, b_irq_rx, b_irq_tx}, 32'h0);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    wr_a(4'h0, 32'hFFFF_FFFF); rd_a(4'h0, d); check("R7 ctrl readback", d, 32'h3);
    wr_a(4'h4, 32'hFFC5_F00A); rd_a(4'h4, d); check("R7 mask readback", d, 32'h0005000A);
    rd_b(4'h4, d); check("R8 mask B untouched", d, 32'h003F003F);
    rd_a(4'h8, d); check("R7 cmd reads zero", d, 32'h0);
    wr_a(4'hC, 32'h0000_003F); rd_a(4'hC, d); check("R7 status write ignored", d, 32'h0);
    wr_a(4'h0, 32'h0); wr_a(4'h4, 32'h003F003F);
  endtask

  task automatic t_set;
    logic [31:0] d;
    wr_a(4'h8, 32'h0005_0000); rd_a(4'hC, d); check("R2 set bits 0,2", d, 32'h05);
    wr_a(4'h8, 32'h0002_0000); rd_a(4'hC, d); check("R2 zeros keep flags", d, 32'h07);
    rd_b(4'hC, d); check("R8 status B independent", d, 32'h0);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wr_b(4'h8, 32'h0000_0004); rd_a(4'hC, d); check("R3 partner clear", d, 32'h03);
    wr_a(4'h8, 32'h0000_0001); rd_a(4'hC, d); check("R3 own flags kept", d, 32'h03);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    @(negedge clk);
    a_sel = 1; a_wr = 1; a_addr = 4'h8; a_wdata = 32'h0008_0000;
    b_sel = 1; b_wr = 1; b_addr = 4'h8; b_wdata = 32'h0000_0009;
    @(negedge clk);
    a_sel = 0; a_wr = 0; b_sel = 0; b_wr = 0;
    rd_a(4'hC, d); check("R4 set beats clear", d, 32'h0A);
  endtask

  task automatic t_rxirq;
    wr_b(4'h0, 32'h1);
    #1 check("R5 all masked", {31'h0, b_irq_rx}, 32'h0);
    wr_b(4'h4, 32'h003F003D);
    #1 check("R5 occupied unmasked", {31'h0, b_irq_rx}, 32'h1);
    wr_b(4'h4, 32'h003F003E);
    #1 check("R5 empty channel unmasked", {31'h0, b_irq_rx}, 32'h0);
    wr_b(4'h4, 32'h003F003D); wr_b(4'h0, 32'h0);
    #1 check("R5 enable off", {31'h0, b_irq_rx}, 32'h0);
  endtask

  task automatic t_txirq;
    wr_a(4'h0, 32'h2); wr_a(4'h4, 32'h0037003F);
    #1 check("R6 busy channel", {31'h0, a_irq_tx}, 32'h0);
    wr_b(4'h8, 32'h0000_0008);
    #1 check("R6 channel freed", {31'h0, a_irq_tx}, 32'h1);
    wr_a(4'h8, 32'h0008_0000);
    #1 check("R6 channel reused", {31'h0, a_irq_tx}, 32'h0);
  endtask

  task automatic t_reverse;
    logic [31:0] d;
    wr_b(4'h8, 32'h0020_0000);
    rd_b(4'hC, d); check("R8 B own flag", d, 32'h20);
    rd_a(4'hC, d); check("R8 A flags unchanged", d, 32'h0A);
    wr_a(4'h0, 32'h1); wr_a(4'h4, 32'h003F001F);
    #1 check("R5 A sees B flag", {31'h0, a_irq_rx}, 32'h1);
    wr_a(4'h8, 32'h0000_0020);
    #1 check("R3 A clears B flag", {31'h0, a_irq_rx}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_readback();
    t_set();
    t_clear();
    t_collide();
    t_rxirq();
    t_txirq();
    t_reverse();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule